// File: doc/BRIEF.md
# Serial Audio Link Input Frame Receiver

This block sits on the controller side of a two-channel audio codec link and deserialises the codec's input stream. It runs on the link bit clock and samples both the frame sync line and the serial data line on the falling edge. The sender changes both lines on the rising edge. A frame is 256 bits long: a 16-bit tag slot followed by twelve 20-bit data slots. Every slot is sent MSB first.

After the last bit of a frame, the receiver presents the whole frame at once as parallel outputs and raises a one-cycle done strobe. The outputs are the codec-ready flag, a 12-bit mask that says which slots hold valid data, and the twelve slot words. The ready flag gates the whole frame. The tag bits gate each slot word separately. A slot word that is not accepted keeps its previous value.

A sync rising edge that arrives mid-frame discards the partial frame and starts a new count. With the default parameters the bit clock is 12.288 MHz and one frame lasts about 20.8 µs, which gives a 48 kHz frame rate.

Top module: `aclink_frame_rx`

## Requirements
- R1: While reset is asserted and after it is released, `frame_done_o`, `codec_ready_o`, `valid_mask_o` and `slot_data_o` are all zero until the first complete frame arrives.
- R2: A frame starts at the falling edge where `sync_i` is sampled high after being sampled low. The bit sampled at the next falling edge is frame bit 0, the codec-ready flag.
- R3: Frame bits 1 to 12 are the tags for slots 1 to 12 in that order. The tag for slot k drives `valid_mask_o[k-1]`, and a 1 means the slot holds valid data.
- R4: Slot k (k = 1 to 12) occupies frame bits 16+20(k-1) to 35+20(k-1), MSB first. It appears on `slot_data_o[20k-1:20(k-1)]` with the first received bit at the top.
- R5: `frame_done_o` is high for exactly one bit-clock cycle and rises at the falling edge that samples frame bit 255. The ready flag, the mask and the slot words change at that same edge.
- R6: In a frame whose ready bit is 1, a slot word is loaded only if its tag is 1. A slot whose tag is 0 keeps its previous value, whatever data arrived in that slot.
- R7: A frame whose ready bit is 0 still pulses `frame_done_o`, but it drives `codec_ready_o` and `valid_mask_o` to zero and leaves every slot word unchanged.
- R8: Frame bits 13 to 15, the low three bits of the tag slot, have no effect on any output.
- R9: If a sync rising edge is sampled when fewer than 255 bits of the current frame have been received, the partial frame is dropped. No done pulse follows, the outputs stay unchanged, and bit counting restarts from that edge.
- R10: If a sync rising edge is sampled at the same edge as frame bit 255, the current frame still completes with its done pulse, and a new frame starts at that edge.
- R11: After a complete frame with no new sync rising edge, serial data is ignored. No done pulse occurs and the outputs hold until the next sync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Link bit clock. All inputs are sampled on its falling edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync from the link |
| sdin_i | input | 1 | Serial input data from the codec |
| frame_done_o | output | 1 | One-cycle strobe for each completed frame |
| codec_ready_o | output | 1 | Ready flag of the last completed frame |
| valid_mask_o | output | 12 | Slot-valid mask. Bit k-1 is slot k. |
| slot_data_o | output | 240 | Slot words. Slot k is at [20k-1:20(k-1)]. |

## Verification
Two functions can fall on the same falling edge: completing a frame and detecting a new sync rise. This is the normal case in back-to-back streaming. The bench provokes it by raising sync together with bit 255. It then sends the next frame's bits straight away with no gap. The check is that the first frame's done pulse arrives on time with its own data, and that the following frame is also received and reported intact. The bench also moves the coincidence one bit earlier, a sync rise at count 254, and judges that this case drops the frame instead.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;
    parameter int SLOT_CNT   = 12;
    parameter int SLOT_BITS  = 20;
    parameter int TAG_BITS   = 16;
    parameter int FRAME_LEN  = TAG_BITS + SLOT_CNT * SLOT_BITS;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
    parameter int FRAME_BITS = aclink_rx_pkg::FRAME_LEN,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             sync_i,
    output logic             bit_take_o,
    output logic             frame_end_o,
    output logic             sync_rise_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             sync_prev;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        sync_rise_o = sync_i & ~st_q.sync_prev;
        bit_take_o  = st_q.active;
        frame_end_o = st_q.active && (st_q.cnt == LAST_BIT);
        count_o     = st_q.cnt;
        st_d.sync_prev = sync_i;
        if (sync_rise_o) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (frame_end_o) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    restart_count_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        sync_rise_o |=> (bit_take_o && count_o == '0));
endmodule

// File: rtl/aclink_frame_shifter.sv
module aclink_frame_shifter #(
    parameter int HIST_W = aclink_rx_pkg::FRAME_LEN - 1
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              bit_i,
    output logic [HIST_W-1:0] hist_o
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en_i) sh_d.hist = {sh_q.hist[HIST_W-2:0], bit_i};
        hist_o = sh_q.hist;
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R4
    msb_first_shift_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        shift_en_i |=> (hist_o[0] == $past(bit_i)));
endmodule

// File: rtl/aclink_frame_rx.sv
module aclink_frame_rx #(
    parameter int SLOTS      = aclink_rx_pkg::SLOT_CNT,
    parameter int SLOT_W     = aclink_rx_pkg::SLOT_BITS,
    parameter int TAG_W      = aclink_rx_pkg::TAG_BITS,
    localparam int FRAME_BITS = TAG_W + SLOTS * SLOT_W,
    localparam int CNT_W      = $clog2(FRAME_BITS),
    localparam int DATA_W     = SLOTS * SLOT_W
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              sdin_i,
    output logic              frame_done_o,
    output logic              codec_ready_o,
    output logic [SLOTS-1:0]  valid_mask_o,
    output logic [DATA_W-1:0] slot_data_o
);
    typedef struct packed {
        logic              done;
        logic              ready;
        logic [SLOTS-1:0]  mask;
        logic [DATA_W-1:0] slots;
    } out_t;

    logic                  bit_take, frame_end, sync_rise;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-2:0] hist;
    logic [FRAME_BITS-1:0] word;
    out_t                  out_d, out_q;

    aclink_frame_timer #(.FRAME_BITS(FRAME_BITS)) i_timer (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .bit_take_o  (bit_take),
        .frame_end_o (frame_end),
        .sync_rise_o (sync_rise),
        .count_o     (bit_cnt)
    );

    aclink_frame_shifter #(.HIST_W(FRAME_BITS - 1)) i_shifter (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .shift_en_i (bit_take),
        .bit_i      (sdin_i),
        .hist_o     (hist)
    );

    always_comb begin
        out_d      = out_q;
        word       = {hist, sdin_i};
        out_d.done = frame_end;
        if (frame_end) begin
            out_d.ready = word[FRAME_BITS-1];
            for (int k = 0; k < SLOTS; k++) begin
                out_d.mask[k] = word[FRAME_BITS-1] & word[FRAME_BITS-2-k];
                if (word[FRAME_BITS-1] && word[FRAME_BITS-2-k])
                    out_d.slots[k*SLOT_W +: SLOT_W] =
                        word[FRAME_BITS-TAG_W-1-k*SLOT_W -: SLOT_W];
            end
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign frame_done_o  = out_q.done;
    assign codec_ready_o = out_q.ready;
    assign valid_mask_o  = out_q.mask;
    assign slot_data_o   = out_q.slots;

    // R5
    done_pulse_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R9
    early_sync_drop_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (sync_rise && bit_take && !frame_end) |=> !frame_done_o);

    // R11
    idle_no_done_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        !bit_take |=> !frame_done_o);

    // R7
    not_ready_mask_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (frame_done_o && !codec_ready_o) |-> (valid_mask_o == '0));

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot_chk
            // R6
            untagged_hold_chk: assert property (@(negedge bclk) disable iff (!rst_n)
                (frame_done_o && !valid_mask_o[g]) |->
                    $stable(slot_data_o[g*SLOT_W +: SLOT_W]));
        end
    endgenerate
endmodule

// File: tb/test_aclink_frame_rx.sv
`timescale 1ns/1ps
module test_aclink_frame_rx;
    localparam int NS = 12;
    localparam int SW = 20;
    localparam int DW = NS * SW;

    logic          bclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_i = 1'b0;
    logic          sdin_i = 1'b0;
    logic          frame_done_o;
    logic          codec_ready_o;
    logic [NS-1:0] valid_mask_o;
    logic [DW-1:0] slot_data_o;

    int            checks = 0;
    int            errors = 0;
    int            exp_done = 0;
    int            seen_done = 0;
    logic          pend = 1'b0;
    logic          exp_ready = 1'b0;
    logic [NS-1:0] exp_mask = '0;
    logic [DW-1:0] exp_slots = '0;

    aclink_frame_rx i_aclink_frame_rx (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .sync_i        (sync_i),
        .sdin_i        (sdin_i),
        .frame_done_o  (frame_done_o),
        .codec_ready_o (codec_ready_o),
        .valid_mask_o  (valid_mask_o),
        .slot_data_o   (slot_data_o)
    );

    always #2.5 bclk = ~bclk;

    task automatic check1(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] build_frame(input logic rdy, input logic [NS-1:0] tags,
                                                 input logic [2:0] low3, input logic [DW-1:0] sl);
        logic [255:0] f;
        f = '0;
        f[255] = rdy;
        for (int k = 0; k < NS; k++) f[254-k] = tags[k];
        f[242:240] = low3;
        for (int k = 0; k < NS; k++) f[239-SW*k -: SW] = sl[SW*k +: SW];
        return f;
    endfunction

    task automatic apply_model(input logic [255:0] f);
        if (f[255]) begin
            exp_ready = 1'b1;
            for (int k = 0; k < NS; k++) begin
                exp_mask[k] = f[254-k];
                if (f[254-k]) exp_slots[SW*k +: SW] = f[239-SW*k -: SW];
            end
        end else begin
            exp_ready = 1'b0;
            exp_mask  = '0;
        end
    endtask

    task automatic drive(input logic s, input logic d);
        @(posedge bclk);
        sync_i = s;
        sdin_i = d;
    endtask

    task automatic send_frame(input logic [255:0] f, input logic start, input logic end_sync);
        if (start) drive(1'b1, 1'b0);
        for (int i = 0; i < 256; i++) begin
            logic s;
            s = (i < 15) || (end_sync && i == 255);
            drive(s, f[255-i]);
        end
        apply_model(f);
        exp_done++;
        pend <= 1'b1;
    endtask

    task automatic send_partial(input int n);
        drive(1'b1, 1'b0);
        for (int i = 0; i < n; i++) drive(i < 15, 1'($urandom));
    endtask

    task automatic check_outputs(input string req);
        check1({req, " ready"}, DW'(codec_ready_o), DW'(exp_ready));
        check1({req, " mask"}, DW'(valid_mask_o), DW'(exp_mask));
        check1({req, " slots"}, slot_data_o, exp_slots);
    endtask

    function automatic logic [DW-1:0] rand_slots();
        logic [DW-1:0] v;
        for (int k = 0; k < NS; k++) v[SW*k +: SW] = 20'($urandom);
        return v;
    endfunction

    // Monitor: done timing (R5) and frame contents (R2 R3 R4 R6 R7 R8)
    always @(posedge bclk) begin
        if (rst_n) begin
            if (pend) begin
                check1("R5 done one cycle after bit 255", DW'(frame_done_o), DW'(1));
                pend <= 1'b0;
            end else if (frame_done_o) begin
                check1("R9/R11 unexpected done pulse", DW'(frame_done_o), DW'(0));
            end
            if (frame_done_o) begin
                seen_done++;
                check_outputs("R2/R3/R4/R6/R7/R8 frame contents");
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] sl;
        logic          last_end;
        void'($urandom(32'd1234));
        repeat (4) @(posedge bclk);
        // R1: reset values
        check1("R1 done", DW'(frame_done_o), '0);
        check_outputs("R1");
        rst_n = 1'b1;
        repeat (3) @(posedge bclk);
        check1("R1 done after release", DW'(frame_done_o), '0);
        check_outputs("R1 after release");

        // R2 R3 R4 R8: all tags set, MSB and LSB markers, low tag bits set
        for (int k = 0; k < NS; k++) sl[SW*k +: SW] = 20'h80001 ^ (20'(k + 1) << 8);
        send_frame(build_frame(1'b1, 12'hFFF, 3'b111, sl), 1'b1, 1'b0);
        repeat (4) drive(1'b0, 1'b0);
        // R6: only slot 1 tagged, garbage elsewhere
        send_frame(build_frame(1'b1, 12'h001, 3'b000, rand_slots()), 1'b1, 1'b0);
        repeat (4) drive(1'b0, 1'b0);
        // R6: only slot 12 tagged, ready bit pattern in tag slot
        send_frame(build_frame(1'b1, 12'h800, 3'b101, rand_slots()), 1'b1, 1'b0);
        repeat (4) drive(1'b0, 1'b0);
        // R7: not ready, all tags set
        send_frame(build_frame(1'b0, 12'hFFF, 3'b111, rand_slots()), 1'b1, 1'b0);

        // R11: idle stream after a frame without new sync
        for (int i = 0; i < 300; i++) drive(1'b0, 1'($urandom));
        check1("R11 no done while idle", DW'(seen_done), DW'(exp_done));
        check_outputs("R11 outputs hold while idle");

        // R9: boundary partial of 254 bits, then a random-length partial
        send_partial(254);
        check1("R9 partial 254 no done", DW'(seen_done), DW'(exp_done));
        check_outputs("R9 partial 254 outputs hold");
        send_frame(build_frame(1'b1, 12'h5A5, 3'b010, rand_slots()), 1'b1, 1'b0);
        send_partial(16 + int'($urandom % 200));
        check_outputs("R9 random partial outputs hold");
        send_frame(build_frame(1'b1, 12'hA5A, 3'b001, rand_slots()), 1'b1, 1'b1);

        // R10: back-to-back frames, sync rises with bit 255
        send_frame(build_frame(1'b1, 12'hFFF, 3'b000, rand_slots()), 1'b0, 1'b1);
        send_frame(build_frame(1'b1, 12'h0F0, 3'b011, rand_slots()), 1'b0, 1'b0);
        repeat (2) drive(1'b0, 1'b0);
        check1("R10 back-to-back frames delivered", DW'(seen_done), DW'(exp_done));

        // Random frames mixing modes
        last_end = 1'b0;
        for (int n = 0; n < 32; n++) begin
            logic rdy, es;
            rdy = ($urandom % 8) != 0;
            es  = ($urandom % 2) != 0;
            if (!last_end && ($urandom % 5) == 0) send_partial(16 + int'($urandom % 239));
            send_frame(build_frame(rdy, 12'($urandom), 3'($urandom), rand_slots()),
                       !last_end, es);
            last_end = es;
        end
        repeat (4) drive(1'b0, 1'b0);
        check1("R5/R9 done count", DW'(seen_done), DW'(exp_done));
        check_outputs("R6 final outputs");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule